// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is a 16-bit free-running timer with a single output compare channel, reached over a byte-wide register bus. A prescaler divides the bus clock by four, and the counter advances once per prescaler period. Software loads a 16-bit compare value as two separate bytes. When the counter takes that value, the block does three things: it sets a hit flag, copies a programmed level onto the compare output pin, and raises an interrupt if interrupts are enabled.

The compare value is loaded high byte first. Writing the high byte holds off match detection until the low byte is written, so a half-updated value never triggers a match. A write to the low byte alone does not hold off matching. The hit flag is cleared in two steps: a read of the status register that sees the flag set, then a write to the low compare byte. Reads are combinational in the same cycle as the address. The read strobe matters only for the flag-clear sequence.

Top module: `oc_timer`

## Requirements
- R1: While reset is applied, the following all read zero: the control register, the status register, both counter bytes, the compare pin and the interrupt.
- R2: The counter increases by exactly one every four bus clock cycles. Counter high byte is at address 4 and low byte at address 5.
- R3: The compare high byte (address 2) and low byte (address 3) read back the last value written to each. A write to one byte leaves the other unchanged, and reset does not alter either byte.
- R4: When the counter takes a value equal to the 16-bit compare value, the hit flag (status address 1, bit 6) becomes 1. It can first be seen while the counter still holds that value.
- R5: On every match the compare pin takes the level bit (control address 0, bit 0) that was set at the time, even when the hit flag is already 1.
- R6: After a write to the compare high byte, no match is detected until the compare low byte has been written. After that write, matching resumes.
- R7: A write to the compare low byte alone does not hold off matching.
- R8: A match is detected only once for each counter value, in the first bus cycle of that value. Clearing the flag while the counter still equals the compare value does not set it again.
- R9: The hit flag clears only when a status read (read strobe asserted) that sees it set is followed by a compare low byte write. A low byte write without that earlier read leaves the flag set.
- R10: The interrupt output is 1 exactly when the hit flag is 1 and the interrupt enable (control bit 6) is 1.
- R11: From reset until the first compare low byte write, no match is detected.
- R12: Control bits other than 0 and 6, and every status bit other than 6, read as zero. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe, used to arm the flag-clear sequence |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| cmp_pin | output | 1 | Compare output level |
| irq | output | 1 | Interrupt request |

## Verification
Compare values are placed a few counter steps ahead of the live counter. Each match is then checked for both its timing and the pin level it produces. One pattern loads the full value with the low byte last. One loads the low byte first and the high byte last, which should give no match until a later low write. One rewrites only the low byte, which should still match. One gets a match while the flag is already set, which separates pin latching from flag state. The clear-while-equal pattern separates matching once per counter value from continuous equality. Placing a reset between loading the compare bytes and the counter reaching them separates retained storage from the start-up hold-off.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE = 3'd0,
    REG_STAT = 3'd1,
    REG_CMPH = 3'd2,
    REG_CMPL = 3'd3,
    REG_CNTH = 3'd4,
    REG_CNTL = 3'd5
  } reg_addr_e;

  localparam int LVL_BIT = 0;
  localparam int IEN_BIT = 6;
  localparam int HIT_BIT = 6;
  localparam logic [BYTE_W-1:0] MODE_MASK = 8'h41;
endpackage

// File: rtl/tc_counter.sv
module tc_counter #(
  parameter int CNT_W = 16,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             srst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             val_new
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0]    pre_q, pre_d;
  logic [CNT_W-1:0] cnt_d;
  logic             tick;

  always_comb begin
    tick    = (pre_q == PW'(DIV - 1));
    pre_d   = tick ? '0 : pre_q + 1'b1;
    cnt_d   = tick ? cnt + 1'b1 : cnt;
    val_new = (pre_q == '0);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pre_q <= '0;
      cnt   <= '0;
    end else begin
      pre_q <= pre_d;
      cnt   <= cnt_d;
    end
  end

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/tc_compare.sv
module tc_compare #(
  parameter int BYTE_W = 8,
  parameter int NB     = 2,
  localparam int CNT_W = BYTE_W * NB
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              val_new,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              match_evt
);
  logic [NB-1:0] lane_we;
  logic          hold_q, hold_d;

  always_comb begin
    lane_we         = '0;
    lane_we[0]      = wr_lo;
    lane_we[NB-1]   = wr_hi;
  end

  // compare bytes are plain storage: no reset, written only by the bus
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (lane_we[g]) cmp_val[g*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_comb begin
    hold_d = hold_q;
    if (wr_lo)      hold_d = 1'b0;
    else if (wr_hi) hold_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) hold_q <= 1'b1;
    else         hold_q <= hold_d;
  end

  assign match_evt = val_new && !hold_q && (cnt == cmp_val);

  assert_hi_blocks_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_hi && !wr_lo) |=> !match_evt);
endmodule

// File: rtl/tc_regs.sv
module tc_regs
  import tc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              match_evt,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic [BYTE_W-1:0] rdata,
  output logic              cmp_pin,
  output logic              irq
);
  logic [BYTE_W-1:0] mode_q, mode_d;
  logic hit_q, hit_d, armed_q, armed_d, pin_d;
  logic wr_mode, rd_stat;

  always_comb begin
    wr_mode = wr_en && (addr == REG_MODE);
    wr_hi   = wr_en && (addr == REG_CMPH);
    wr_lo   = wr_en && (addr == REG_CMPL);
    rd_stat = rd_en && (addr == REG_STAT);

    mode_d = wr_mode ? (wdata & MODE_MASK) : mode_q;

    hit_d = hit_q;
    if (match_evt)           hit_d = 1'b1;
    else if (wr_lo && armed_q) hit_d = 1'b0;

    armed_d = armed_q;
    if (wr_lo)                armed_d = 1'b0;
    else if (rd_stat && hit_q) armed_d = 1'b1;

    pin_d = match_evt ? mode_q[LVL_BIT] : cmp_pin;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q  <= '0;
      hit_q   <= 1'b0;
      armed_q <= 1'b0;
      cmp_pin <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      hit_q   <= hit_d;
      armed_q <= armed_d;
      cmp_pin <= pin_d;
    end
  end

  assign irq = hit_q & mode_q[IEN_BIT];

  always_comb begin
    rdata = '0;
    case (addr)
      REG_MODE: rdata = mode_q;
      REG_STAT: rdata[HIT_BIT] = hit_q;
      REG_CMPH: rdata = cmp_val[CNT_W-1 -: BYTE_W];
      REG_CMPL: rdata = cmp_val[BYTE_W-1:0];
      REG_CNTH: rdata = cnt[CNT_W-1 -: BYTE_W];
      REG_CNTL: rdata = cnt[BYTE_W-1:0];
      default:  rdata = '0;
    endcase
  end

  assert_match_sets_R4: assert property (@(posedge clk) disable iff (!srst_n)
    match_evt |=> hit_q);
  assert_rise_has_cause_R4: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(hit_q) |-> $past(match_evt));
  assert_pin_level_R5: assert property (@(posedge clk) disable iff (!srst_n)
    match_evt |=> (cmp_pin == $past(mode_q[LVL_BIT])));
  assert_unarmed_keeps_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (!match_evt && !armed_q) |=> (hit_q == $past(hit_q)));
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import tc_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              cmp_pin,
  output logic              irq
);
  localparam int NB    = 2;
  localparam int CNT_W = BYTE_W * NB;

  logic [1:0]       rs_q;
  logic             srst_n;
  logic [CNT_W-1:0] cnt, cmp_val;
  logic             val_new, match_evt, wr_hi, wr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  tc_counter #(.CNT_W(CNT_W), .DIV(DIV)) u_cnt (
    .clk(clk), .srst_n(srst_n), .cnt(cnt), .val_new(val_new)
  );

  tc_compare #(.BYTE_W(BYTE_W), .NB(NB)) u_cmp (
    .clk(clk), .srst_n(srst_n), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wdata(wdata), .cnt(cnt), .val_new(val_new),
    .cmp_val(cmp_val), .match_evt(match_evt)
  );

  tc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .srst_n(srst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .cmp_val(cmp_val), .cnt(cnt), .match_evt(match_evt),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .rdata(rdata), .cmp_pin(cmp_pin), .irq(irq)
  );

  assert_single_match_R8: assert property (@(posedge clk) disable iff (!srst_n)
    match_evt |=> !match_evt);
endmodule

// File: tb/tb_oc_timer.sv
module tb_oc_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata;
  wire  [7:0] rdata;
  wire        cmp_pin, irq;

  always #2 clk = ~clk;

  oc_timer dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cmp_pin(cmp_pin), .irq(irq)
  );

  int   total = 0;
  int   bad   = 0;
  logic exp_q[$];
  logic irq_prev = 1'b0;
  logic [7:0] v;
  int   n, c, c2;
  bit   f;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected pin level on each rising interrupt
  always @(negedge clk) begin
    logic e;
    if (irq && !irq_prev) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected interrupt", 1, 0);
      else begin
        e = exp_q.pop_front();
        check(cmp_pin == e, "R5 scoreboard pin level", cmp_pin, e);
      end
    end
    irq_prev = irq;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog run hung actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic idle();
    @(negedge clk); wr_en = 0; rd_en = 0;
  endtask
  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); wr_en = 0; rd_en = 0; addr = a; #1 d = rdata;
  endtask
  task automatic strobe_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); wr_en = 0; rd_en = 1; addr = a; #1 d = rdata;
  endtask
  task automatic write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); rd_en = 0; addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic get_cnt(output int r);
    logic [7:0] h1, l, h2;
    peek(3'd4, h1); peek(3'd5, l); peek(3'd4, h2);
    r = (h1 != h2) ? {16'h0, h2, 8'h00} : {16'h0, h1, l};
  endtask
  task automatic set_cmp(input int val);
    write(3'd2, val[15:8]); write(3'd3, val[7:0]);
  endtask
  task automatic wait_flag(input bit strobe, output bit found);
    found = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); wr_en = 0; rd_en = strobe; addr = 3'd1; #1;
      if (rdata[6]) begin found = 1; return; end
    end
    rd_en = 0;
  endtask
  task automatic wait_past(input int val);
    int m;
    for (int i = 0; i < 100; i++) begin
      get_cnt(m);
      if (m >= val + 2) return;
    end
  endtask

  initial begin
    rst_n = 0; addr = 0; wr_en = 0; rd_en = 0; wdata = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    peek(3'd0, v); check(v == 0, "R1 control", v, 0);
    peek(3'd1, v); check(v == 0, "R1 status", v, 0);
    peek(3'd4, v); check(v == 0, "R1 counter high", v, 0);
    peek(3'd5, v); check(v == 0, "R1 counter low", v, 0);
    check(cmp_pin == 0 && irq == 0, "R1 pin and irq", {cmp_pin, irq}, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) idle();

    // R2 counter rate
    begin
      logic [7:0] a, b, d;
      peek(3'd5, a); repeat (3) @(negedge clk); peek(3'd5, b);
      check(8'(b - a) == 1, "R2 four-cycle step", 8'(b - a), 1);
      repeat (7) @(negedge clk); peek(3'd5, d);
      check(8'(d - b) == 2, "R2 eight-cycle step", 8'(d - b), 2);
    end

    // R3 byte storage independence
    write(3'd3, 8'h3C); write(3'd2, 8'hA5);
    peek(3'd3, v); check(v == 8'h3C, "R3 low kept after high write", v, 8'h3C);
    peek(3'd2, v); check(v == 8'hA5, "R3 high readback", v, 8'hA5);
    write(3'd3, 8'h5A);
    peek(3'd2, v); check(v == 8'hA5, "R3 high kept after low write", v, 8'hA5);
    peek(3'd3, v); check(v == 8'h5A, "R3 low readback", v, 8'h5A);

    // R12 reserved bits
    write(3'd0, 8'hFF); peek(3'd0, v); check(v == 8'h41, "R12 control mask", v, 8'h41);
    write(3'd1, 8'hFF); peek(3'd1, v); check(v == 8'h00, "R12 status write ignored", v, 0);
    write(3'd0, 8'h41);

    // R4 basic match with level 1
    get_cnt(n); c = n + 12; exp_q.push_back(1'b1); set_cmp(c);
    wait_flag(0, f); check(f, "R4 flag set", f, 1);
    peek(3'd5, v); check(v == c[7:0], "R4 counter low at flag", v, c[7:0]);
    peek(3'd4, v); check(v == c[15:8], "R4 counter high at flag", v, c[15:8]);
    check(cmp_pin == 1, "R5 pin high", cmp_pin, 1);

    // R5 latch while flag already set; R9 unarmed write keeps flag
    write(3'd0, 8'h40);
    get_cnt(n); c = n + 12; set_cmp(c);
    peek(3'd1, v); check(v[6] == 1, "R9 flag kept without read", v, 8'h40);
    f = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (!cmp_pin) begin f = 1; break; end
    end
    check(f, "R5 pin relatched with flag set", f, 1);
    peek(3'd5, v); check(v == c[7:0], "R5 relatch at compare value", v, c[7:0]);

    // R9 clear sequence
    strobe_read(3'd1, v); write(3'd3, c[7:0]);
    peek(3'd1, v); check(v == 0, "R9 flag cleared", v, 0);
    check(irq == 0, "R10 irq follows flag clear", irq, 0);

    // R8 clear while still equal: no second detection
    write(3'd0, 8'h41);
    get_cnt(n); c = n + 12; exp_q.push_back(1'b1); set_cmp(c);
    wait_flag(1, f); check(f, "R8 first detection", f, 1);
    write(3'd3, c[7:0]);
    peek(3'd1, v); check(v == 0, "R8 no redetect same value", v, 0);
    f = 0;
    for (int i = 0; i < 8; i++) begin
      peek(3'd1, v); if (v[6]) f = 1;
    end
    check(!f, "R8 flag stays clear", f, 0);

    // R6 high write last holds off match
    write(3'd0, 8'h40);
    get_cnt(n); c = n + 12;
    write(3'd3, c[7:0]); write(3'd2, c[15:8]);
    wait_past(c);
    peek(3'd1, v); check(v == 0, "R6 no match while held", v, 0);
    check(cmp_pin == 1, "R6 pin unchanged while held", cmp_pin, 1);
    get_cnt(n); c2 = n + 12; exp_q.push_back(1'b0);
    if (c2[15:8] != c[15:8]) write(3'd2, c2[15:8]);
    write(3'd3, c2[7:0]);
    wait_flag(0, f); check(f, "R6 match resumes after low write", f, 1);
    check(cmp_pin == 0, "R6 pin after resume", cmp_pin, 0);
    strobe_read(3'd1, v); write(3'd3, c2[7:0]);

    // R7 low-only write does not hold off
    write(3'd0, 8'h41);
    for (int i = 0; i < 200; i++) begin
      get_cnt(n);
      if (n[7:0] < 8'hC0) break;
    end
    get_cnt(n); c = n + 12; set_cmp(c + 32);
    exp_q.push_back(1'b1); write(3'd3, c[7:0]);
    wait_flag(0, f); check(f, "R7 low-only write matches", f, 1);
    peek(3'd5, v); check(v == c[7:0], "R7 match value", v, c[7:0]);
    check(cmp_pin == 1, "R7 pin level", cmp_pin, 1);
    strobe_read(3'd1, v); write(3'd3, c[7:0]);

    // R10 interrupt gating
    write(3'd0, 8'h00);
    get_cnt(n); c = n + 12; set_cmp(c);
    wait_flag(0, f); check(f && irq == 0, "R10 no irq when disabled", irq, 0);
    exp_q.push_back(1'b0); write(3'd0, 8'h40);
    peek(3'd1, v); check(irq == 1, "R10 irq when enabled", irq, 1);
    strobe_read(3'd1, v); write(3'd3, c[7:0]);
    peek(3'd1, v); check(irq == 0, "R10 irq after clear", irq, 0);

    // R3 retained over reset, R11 start-up hold-off
    write(3'd0, 8'h00); set_cmp(3);
    @(negedge clk); rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
    peek(3'd2, v); check(v == 8'h00, "R3 high kept over reset", v, 0);
    peek(3'd3, v); check(v == 8'h03, "R3 low kept over reset", v, 3);
    repeat (40) idle();
    peek(3'd1, v); check(v == 0, "R11 no match before low write", v, 0);
    get_cnt(n); c = n + 10; write(3'd3, c[7:0]);
    wait_flag(0, f); check(f, "R11 match after low write", f, 1);

    check(exp_q.size() == 0, "R4 all expected matches seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule